// File: doc/BRIEF.md
# Backup-Battery Switchover Controller

This block decides, cycle by cycle, whether a switched supply rail is fed from the main supply or from a backup battery. It works on digitized flags from external comparators: the supply is below its reset threshold, the supply is below the battery voltage, the battery is below its health threshold, main supply is present, and a request to seal the battery off again. It drives the select lines for the two analog switches, a battery-on indicator, a battery-health indicator and an enable for a test load.

After reset the battery is sealed off, so the rail can only come up from main supply. The first time main supply is seen, the seal opens and the rail runs from main. The rail moves to the battery only when both supply flags are true in the same cycle. Turning the seal back on needs main supply to be absent while a seal request is applied.

While on main supply, a scheduler loads the battery periodically. It waits a short initial delay, then enables the load for a fixed window. At the end of that window it latches the health flag. Further windows follow after a long gap. In backup mode the schedule is suspended and the health indicator is forced low. Each return to main supply restarts the schedule with the short delay. All intervals are parameters counted in clock cycles.

Top module: `bkup_switch_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all five outputs are low and the battery is sealed.
- R2: While sealed, sel_bat stays low and sel_main stays low whatever the two supply flags show.
- R3: When main_ok is high while sealed, sel_main is high one cycle later and the seal is cleared.
- R4: From main mode, sel_bat rises one cycle after vcc_low_rst and vcc_below_bat are both high in the same cycle. Either flag alone leaves sel_main high.
- R5: From backup mode, the block returns to main one cycle after either supply flag goes low.
- R6: bat_on equals sel_bat, and sel_main and sel_bat are never high together.
- R7: With main_ok low and reseal_req high, both selects are low one cycle later and the seal is set again. A reseal_req with main_ok high has no effect.
- R8: In every stay in main mode, load_en first rises INIT_DLY cycles after the cycle in which sel_main rose. It then stays high for exactly TEST_LEN cycles.
- R9: Each later test window starts GAP cycles after the previous window ended.
- R10: At the edge where a window ends, bat_good takes the inverse of bat_low sampled in the window's last cycle. It holds that value until the next window ends, and bat_low outside a window has no effect. The value after reset is 0.
- R11: In backup mode, and while sealed, load_en and bat_good are low.
- R12: On a return from backup, bat_good again shows the held result, and the schedule restarts with INIT_DLY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_ok | input | 1 | Main supply present |
| reseal_req | input | 1 | Request to seal the battery off again |
| vcc_low_rst | input | 1 | Supply below the reset threshold |
| vcc_below_bat | input | 1 | Supply below the battery voltage |
| bat_low | input | 1 | Battery below its health threshold |
| sel_main | output | 1 | Connect the rail to main supply |
| sel_bat | output | 1 | Connect the rail to the battery |
| bat_on | output | 1 | Backup mode indicator |
| bat_good | output | 1 | Latched battery health, forced low outside main mode |
| load_en | output | 1 | Battery test load enable |

## Verification
Mode changes are due one clock edge after the flags that cause them. The bench drives every input on a falling edge, steps a counted number of rising edges, and samples the outputs on the next falling edge. The load window is checked on both sides of each boundary: low after INIT_DLY-1 edges and high after INIT_DLY edges, counted from the edge on which sel_main rose. It is checked the same way at TEST_LEN and at GAP. bat_good is sampled in the last cycle of a window, where it must still show the old result, and again one edge later, where it must show the new one.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
  typedef enum logic [1:0] {
    PWR_SEALED = 2'd0,
    PWR_MAIN   = 2'd1,
    PWR_BATT   = 2'd2
  } pwr_mode_t;
endpackage

// File: rtl/bkup_mode_fsm.sv
module bkup_mode_fsm
  import bkup_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      main_ok,
  input  logic      reseal_req,
  input  logic      vcc_low_rst,
  input  logic      vcc_below_bat,
  output pwr_mode_t mode
);
  pwr_mode_t mode_nxt;
  logic      reseal_ok;
  logic      need_batt;

  assign reseal_ok = !main_ok && reseal_req;
  assign need_batt = vcc_low_rst && vcc_below_bat;

  always_comb begin
    mode_nxt = mode;
    case (mode)
      PWR_SEALED: if (main_ok) mode_nxt = PWR_MAIN;
      PWR_MAIN: begin
        if (reseal_ok)      mode_nxt = PWR_SEALED;
        else if (need_batt) mode_nxt = PWR_BATT;
      end
      PWR_BATT: begin
        if (reseal_ok)       mode_nxt = PWR_SEALED;
        else if (!need_batt) mode_nxt = PWR_MAIN;
      end
      default: mode_nxt = PWR_SEALED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= PWR_SEALED;
    else     mode <= mode_nxt;
  end
endmodule

// File: rtl/bkup_test_sched.sv
module bkup_test_sched #(
  parameter int unsigned INIT_DLY = 16,
  parameter int unsigned GAP      = 40,
  parameter int unsigned TEST_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic bat_low,
  output logic load_en,
  output logic health_q
);
  localparam int unsigned MAX_A = (INIT_DLY > GAP) ? INIT_DLY : GAP;
  localparam int unsigned MAX_C = (MAX_A > TEST_LEN) ? MAX_A : TEST_LEN;
  localparam int unsigned CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] INIT_LD = CW'(INIT_DLY - 1);
  localparam logic [CW-1:0] GAP_LD  = CW'(GAP - 1);
  localparam logic [CW-1:0] TEST_LD = CW'(TEST_LEN - 1);

  logic          in_test;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_test  <= 1'b0;
      cnt      <= INIT_LD;
      health_q <= 1'b0;
    end else if (!run) begin
      in_test <= 1'b0;
      cnt     <= INIT_LD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (in_test) begin
      in_test  <= 1'b0;
      cnt      <= GAP_LD;
      health_q <= !bat_low;
    end else begin
      in_test <= 1'b1;
      cnt     <= TEST_LD;
    end
  end

  assign load_en = in_test && run;
endmodule

// File: rtl/bkup_switch_ctrl.sv
module bkup_switch_ctrl
  import bkup_pkg::*;
#(
  parameter int unsigned INIT_DLY = 16,
  parameter int unsigned GAP      = 40,
  parameter int unsigned TEST_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic main_ok,
  input  logic reseal_req,
  input  logic vcc_low_rst,
  input  logic vcc_below_bat,
  input  logic bat_low,
  output logic sel_main,
  output logic sel_bat,
  output logic bat_on,
  output logic bat_good,
  output logic load_en
);
  pwr_mode_t mode;
  logic      health_q;
  logic      on_main;

  bkup_mode_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .main_ok       (main_ok),
    .reseal_req    (reseal_req),
    .vcc_low_rst   (vcc_low_rst),
    .vcc_below_bat (vcc_below_bat),
    .mode          (mode)
  );

  assign on_main = (mode == PWR_MAIN);

  bkup_test_sched #(
    .INIT_DLY (INIT_DLY),
    .GAP      (GAP),
    .TEST_LEN (TEST_LEN)
  ) u_sched (
    .clk      (clk),
    .rst      (rst),
    .run      (on_main),
    .bat_low  (bat_low),
    .load_en  (load_en),
    .health_q (health_q)
  );

  assign sel_main = on_main;
  assign sel_bat  = (mode == PWR_BATT);
  assign bat_on   = (mode == PWR_BATT);
  assign bat_good = health_q && on_main;
endmodule

// File: rtl/bkup_switch_ctrl_chk.sv
module bkup_switch_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic main_ok,
  input logic reseal_req,
  input logic vcc_low_rst,
  input logic vcc_below_bat,
  input logic bat_low,
  input logic sel_main,
  input logic sel_bat,
  input logic bat_on,
  input logic bat_good,
  input logic load_en
);
  // R6
  sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_main, sel_bat}) && (bat_on == sel_bat));

  // R4
  batt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_bat) |-> $past(vcc_low_rst && vcc_below_bat));

  // R2
  sealed_no_batt_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_main && !sel_bat) |=> !sel_bat);

  // R3
  powerup_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_main && !sel_bat && main_ok) |=> sel_main);

  // R7
  reseal_chk: assert property (@(posedge clk) disable iff (rst)
    (!main_ok && reseal_req) |=> (!sel_main && !sel_bat));

  // R11
  batt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_main |-> (!load_en && !bat_good));

  // R10
  health_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_main) && sel_main && !$fell(load_en)) |-> $stable(bat_good));
endmodule

bind bkup_switch_ctrl bkup_switch_ctrl_chk u_chk (.*);

// File: tb/tb_bkup_switch_ctrl.sv
`timescale 1ns/1ps
module tb_bkup_switch_ctrl;
  localparam int INIT_DLY = 16;
  localparam int GAP      = 40;
  localparam int TEST_LEN = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic main_ok = 0, reseal_req = 0, vcc_low_rst = 0, vcc_below_bat = 0, bat_low = 0;
  logic sel_main, sel_bat, bat_on, bat_good, load_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bkup_switch_ctrl #(.INIT_DLY(INIT_DLY), .GAP(GAP), .TEST_LEN(TEST_LEN)) dut (
    .clk(clk), .rst(rst), .main_ok(main_ok), .reseal_req(reseal_req),
    .vcc_low_rst(vcc_low_rst), .vcc_below_bat(vcc_below_bat), .bat_low(bat_low),
    .sel_main(sel_main), .sel_bat(sel_bat), .bat_on(bat_on),
    .bat_good(bat_good), .load_en(load_en));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_sel(input string req, input logic m, input logic b);
    chk(req, "sel_main", sel_main, m);
    chk(req, "sel_bat", sel_bat, b);
    chk(req, "bat_on", bat_on, b);
  endtask

  task automatic t_reset;
    rst = 1; step(3);
    chk_sel("R1", 0, 0);
    chk("R1", "load_en", load_en, 0);
    rst = 0; step(1);
    chk_sel("R1", 0, 0);
    chk("R1", "bat_good", bat_good, 0);
    chk("R1", "load_en", load_en, 0);
  endtask

  task automatic t_sealed;
    vcc_low_rst = 1; vcc_below_bat = 1; step(3);
    chk_sel("R2", 0, 0);
    vcc_low_rst = 0; vcc_below_bat = 0;
  endtask

  task automatic t_powerup_tests;
    main_ok = 1; step(1);
    chk_sel("R3", 1, 0);
    step(INIT_DLY - 1); chk("R8", "load_en early", load_en, 0);
    step(1);            chk("R8", "load_en start", load_en, 1);
    step(TEST_LEN - 1); chk("R8", "load_en last", load_en, 1);
    chk("R10", "bat_good before end", bat_good, 0);
    step(1);            chk("R8", "load_en end", load_en, 0);
    chk("R10", "bat_good good", bat_good, 1);
    bat_low = 1;
    step(GAP - 1);      chk("R9", "load_en gap", load_en, 0);
    chk("R10", "bat_good ignores gap", bat_good, 1);
    step(1);            chk("R9", "load_en 2nd", load_en, 1);
    step(TEST_LEN - 1); chk("R10", "bat_good held", bat_good, 1);
    step(1);            chk("R10", "bat_good low", bat_good, 0);
    chk("R9", "load_en 2nd end", load_en, 0);
    bat_low = 0;
    step(GAP);          chk("R9", "load_en 3rd", load_en, 1);
    step(TEST_LEN);     chk("R10", "bat_good recovered", bat_good, 1);
  endtask

  task automatic t_backup;
    vcc_low_rst = 1; vcc_below_bat = 0; step(2);
    chk_sel("R4", 1, 0);
    vcc_low_rst = 0; vcc_below_bat = 1; step(2);
    chk_sel("R4", 1, 0);
    vcc_low_rst = 1; step(1);
    chk_sel("R4", 0, 1);
    chk("R11", "bat_good in backup", bat_good, 0);
    step(INIT_DLY + TEST_LEN + 4);
    chk("R11", "load_en in backup", load_en, 0);
    chk("R11", "bat_good still low", bat_good, 0);
    chk_sel("R6", 0, 1);
    vcc_low_rst = 0; step(1);
    chk_sel("R5", 1, 0);
    chk("R12", "bat_good restored", bat_good, 1);
    step(INIT_DLY - 1); chk("R12", "load_en early", load_en, 0);
    step(1);            chk("R12", "load_en restart", load_en, 1);
    step(TEST_LEN);     chk("R12", "load_en done", load_en, 0);
    vcc_below_bat = 0;
  endtask

  task automatic t_reseal;
    reseal_req = 1; step(2);
    chk_sel("R7", 1, 0);
    reseal_req = 0; main_ok = 0; step(1);
    chk_sel("R7", 1, 0);
    reseal_req = 1; step(1);
    chk_sel("R7", 0, 0);
    chk("R11", "bat_good sealed", bat_good, 0);
    reseal_req = 0; vcc_low_rst = 1; vcc_below_bat = 1; step(3);
    chk_sel("R2", 0, 0);
    main_ok = 1; step(1);
    chk_sel("R3", 1, 0);
    vcc_low_rst = 0; vcc_below_bat = 0; step(2);
    chk_sel("R3", 1, 0);
  endtask

  initial begin
    t_reset();
    t_sealed();
    t_powerup_tests();
    t_backup();
    t_reseal();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule